// File: doc/BRIEF.md
# Unified forward/inverse transform butterfly

This block is the arithmetic heart of a number-theoretic transform engine. Every clock cycle it can accept one butterfly job, made of two coefficients, one twiddle factor and a mode bit. Some fixed number of cycles later it returns two result coefficients, reduced modulo a prime `q` that is supplied at run time. One datapath serves both directions of the transform. In forward mode the twiddle product is added to and subtracted from the first coefficient. In inverse mode the sum and the difference are each halved, and the halved difference is then scaled by the twiddle.

The halving is a modular division by two. It uses only an adder, a shift and a multiplexer. The modular multiplier is a pipelined submodule with a fixed latency set by `MUL_LAT`. Delay registers on the side path keep both outputs aligned for any value of that parameter. The mode bit travels with the job, so forward and inverse jobs can be mixed from one cycle to the next. A result that emerges is flagged by `out_valid`. The modulus must stay constant while jobs are in flight, must be odd, and all inputs must be below it.

Top module: `bfly_unit`

## Requirements
- R1: With `in_mode` = 0 (forward), `out_y0` equals (a + b·c) mod q.
- R2: With `in_mode` = 0 (forward), `out_y1` equals (a − b·c) mod q, wrapped into the range 0..q−1.
- R3: With `in_mode` = 1 (inverse), `out_y0` equals (a + b)·2⁻¹ mod q. This holds both when the reduced sum is even and when it is odd, in which case the block computes (sum + q)/2.
- R4: With `in_mode` = 1 (inverse), `out_y1` equals (a − b)·c·2⁻¹ mod q.
- R5: Counting the rising edge that samples `in_valid` = 1 as the first edge, the result appears right after edge number MUL_LAT+2, in both modes, with `out_valid` = 1. `out_valid` is never 1 before MUL_LAT+2 edges have passed since reset was released.
- R6: A new job is accepted on every cycle. Jobs issued back to back, with the mode changing from one job to the next, each produce their own correct result, in issue order.
- R7: While `rst` is high and on the first cycle after it, `out_valid`, `out_y0` and `out_y1` are 0. Jobs in flight when reset is asserted never produce a result.
- R8: Whenever `out_valid` is 1, both outputs are below q.
- R9: In a cycle where no result emerges (`out_valid` = 0), `out_y0` and `out_y1` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| modulus | input | W | Odd modulus q; held constant while jobs are in flight |
| in_valid | input | 1 | A job is presented this cycle |
| in_mode | input | 1 | 0 = forward butterfly, 1 = inverse butterfly |
| in_a | input | W | First coefficient, below q |
| in_b | input | W | Second coefficient, below q |
| in_tw | input | W | Twiddle factor, below q |
| out_valid | output | 1 | A result is present on the outputs |
| out_y0 | output | W | First result coefficient |
| out_y1 | output | W | Second result coefficient |

## Verification
The two functions that can fall in the same cycle are the forward combine at the output stage and the inverse pre-halving at the input stage. They meet whenever one job of each mode is in flight together. The shared multiplier then works on a forward operand and an inverse operand in adjacent slots. The stimulus table provokes this by issuing alternating forward and inverse jobs back to back, near the top of a 32-bit modulus and around the odd-halving and wrap cases. Each result is judged against independently computed modular values, together with its exact arrival cycle.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic {
        BF_FWD = 1'b0,
        BF_INV = 1'b1
    } bf_mode_e;

    localparam int unsigned DEF_COEF_W  = 32;
    localparam int unsigned DEF_MUL_LAT = 3;

    // cycles from the sampling edge to the result, counting that edge
    function automatic int unsigned bf_latency(input int unsigned mul_lat);
        return mul_lat + 2;
    endfunction

endpackage

// File: rtl/bfly_modadd.sv
module bfly_modadd #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] q,
    output logic [W-1:0] sum
);
    logic [W:0] raw;
    logic [W:0] corr;

    always_comb begin
        raw  = {1'b0, x} + {1'b0, y};
        corr = raw - {1'b0, q};
        sum  = (raw >= {1'b0, q}) ? corr[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/bfly_modsub.sv
module bfly_modsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] q,
    output logic [W-1:0] diff
);
    logic [W:0] wrapped;
    logic [W-1:0] plain;

    always_comb begin
        plain   = x - y;
        wrapped = {1'b0, x} + {1'b0, q} - {1'b0, y};
        diff    = (x >= y) ? plain : wrapped[W-1:0];
    end
endmodule

// File: rtl/bfly_halve.sv
module bfly_halve #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] q,
    output logic [W-1:0] half
);
    logic [W:0] lifted;

    always_comb begin
        lifted = x[0] ? ({1'b0, x} + {1'b0, q}) : {1'b0, x};
        half   = W'(lifted >> 1);
    end
endmodule

// File: rtl/bfly_modmul.sv
module bfly_modmul #(
    parameter int unsigned W   = 32,
    parameter int unsigned LAT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] q,
    output logic [W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] wide;
    logic [W-1:0]  reduced;
    logic [W-1:0]  pipe [LAT];

    always_comb begin
        wide    = {{W{1'b0}}, x} * {{W{1'b0}}, y};
        reduced = W'(wide % {{W{1'b0}}, q});
    end

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= reduced;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= '0;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign prod = pipe[LAT-1];
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
    import bfly_pkg::*;
#(
    parameter int unsigned W       = DEF_COEF_W,
    parameter int unsigned MUL_LAT = DEF_MUL_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] modulus,
    input  logic         in_valid,
    input  logic         in_mode,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_tw,
    output logic         out_valid,
    output logic [W-1:0] out_y0,
    output logic [W-1:0] out_y1
);
    typedef struct packed {
        logic         vld;
        bf_mode_e     mode;
        logic [W-1:0] side;
        logic [W-1:0] mop;
        logic [W-1:0] tw;
    } front_t;

    typedef struct packed {
        logic         vld;
        bf_mode_e     mode;
        logic [W-1:0] side;
    } side_t;

    // ---------------- front stage: inverse pre-halving ----------------
    logic [W-1:0] pre_sum, pre_dif, pre_sum_h, pre_dif_h;
    front_t       front_d, front_q;

    bfly_modadd #(.W(W)) u_pre_add (.x(in_a), .y(in_b), .q(modulus), .sum(pre_sum));
    bfly_modsub #(.W(W)) u_pre_sub (.x(in_a), .y(in_b), .q(modulus), .diff(pre_dif));
    bfly_halve  #(.W(W)) u_half_s  (.x(pre_sum), .q(modulus), .half(pre_sum_h));
    bfly_halve  #(.W(W)) u_half_d  (.x(pre_dif), .q(modulus), .half(pre_dif_h));

    always_comb begin
        front_d.vld  = in_valid;
        front_d.mode = bf_mode_e'(in_mode);
        front_d.tw   = in_tw;
        if (bf_mode_e'(in_mode) == BF_INV) begin
            front_d.side = pre_sum_h;
            front_d.mop  = pre_dif_h;
        end else begin
            front_d.side = in_a;
            front_d.mop  = in_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) front_q <= '0;
        else     front_q <= front_d;
    end

    // ---------------- shared multiplier ----------------
    logic [W-1:0] tw_prod;

    bfly_modmul #(.W(W), .LAT(MUL_LAT)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .x    (front_q.mop),
        .y    (front_q.tw),
        .q    (modulus),
        .prod (tw_prod)
    );

    // ---------------- balancing delay line ----------------
    side_t bal [MUL_LAT];

    always_ff @(posedge clk) begin
        if (rst) bal[0] <= '0;
        else     bal[0] <= '{vld: front_q.vld, mode: front_q.mode, side: front_q.side};
    end

    for (genvar i = 1; i < MUL_LAT; i++) begin : g_bal
        always_ff @(posedge clk) begin
            if (rst) bal[i] <= '0;
            else     bal[i] <= bal[i-1];
        end
    end

    side_t bal_tail;
    assign bal_tail = bal[MUL_LAT-1];

    // ---------------- back stage: forward combine ----------------
    logic [W-1:0] post_sum, post_dif;
    logic [W-1:0] res0, res1;

    bfly_modadd #(.W(W)) u_post_add (.x(bal_tail.side), .y(tw_prod), .q(modulus), .sum(post_sum));
    bfly_modsub #(.W(W)) u_post_sub (.x(bal_tail.side), .y(tw_prod), .q(modulus), .diff(post_dif));

    always_comb begin
        if (bal_tail.mode == BF_INV) begin
            res0 = bal_tail.side;
            res1 = tw_prod;
        end else begin
            res0 = post_sum;
            res1 = post_dif;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y0    <= '0;
            out_y1    <= '0;
        end else begin
            out_valid <= bal_tail.vld;
            if (bal_tail.vld) begin
                out_y0 <= res0;
                out_y1 <= res1;
            end
        end
    end
endmodule

// File: rtl/bfly_unit_chk.sv
module bfly_unit_chk
    import bfly_pkg::*;
#(
    parameter int unsigned W       = DEF_COEF_W,
    parameter int unsigned MUL_LAT = DEF_MUL_LAT
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] modulus,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_y0,
    input logic [W-1:0] out_y1
);
    localparam int unsigned LAT_TOT = bf_latency(MUL_LAT);

    logic [15:0] since_rst;
    logic [15:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            inflight  <= '0;
        end else begin
            if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
            inflight <= inflight + 16'(in_valid) - 16'(out_valid);
        end
    end

    assert_early_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 16'(LAT_TOT)) |-> !out_valid);

    assert_inflight_R5: assert property (@(posedge clk) disable iff (rst)
        (inflight <= 16'(LAT_TOT + 1)) && (out_valid -> inflight != 16'd0));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y0 < modulus) && (out_y1 < modulus));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_y0) && $stable(out_y1));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> !out_valid && out_y0 == '0 && out_y1 == '0);
endmodule

bind bfly_unit bfly_unit_chk #(.W(W), .MUL_LAT(MUL_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .modulus   (modulus),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y0    (out_y0),
    .out_y1    (out_y1)
);

// File: tb/bfly_unit_test.sv
module bfly_unit_test;
    localparam int unsigned W       = 32;
    localparam int unsigned MUL_LAT = 3;
    localparam int          LAT     = MUL_LAT + 2;
    localparam logic [31:0] QA      = 32'd4294967291;
    localparam logic [31:0] QM      = 32'd4294967290;

    typedef struct packed {
        logic        m;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b0, 32'd5,          32'd7,          32'd3},
        '{1'b1, 32'd5,          32'd7,          32'd3},
        '{1'b0, QM,             QM,             QM},
        '{1'b1, QM,             QM,             QM},
        '{1'b0, 32'd0,          QM,             32'd1},
        '{1'b1, 32'd0,          32'd1,          32'd9},
        '{1'b0, 32'd123456789,  32'd987654321,  32'd2147483647},
        '{1'b1, 32'd4000000000, 32'd3999999999, 32'd77},
        '{1'b0, 32'd0,          32'd0,          32'd0},
        '{1'b1, 32'd1,          32'd0,          QM},
        '{1'b1, 32'd2,          32'd4,          32'd5},
        '{1'b0, 32'd3000000000, 32'd3000000000, 32'd3000000000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] modulus = QA;
    logic         in_valid = 1'b0;
    logic         in_mode = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_tw = '0;
    logic         out_valid;
    logic [W-1:0] out_y0, out_y1;

    bfly_unit #(.W(W), .MUL_LAT(MUL_LAT)) uut (
        .clk(clk), .rst(rst), .modulus(modulus),
        .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .in_tw(in_tw),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1)
    );

    always #2 clk = ~clk;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] exp0 [256];
    logic [31:0] exp1 [256];
    logic        expm [256];
    int          issue [256];
    int          wr = 0;
    int          rd = 0;
    logic        mon_en = 1'b0;
    logic        have_last = 1'b0;
    logic [31:0] last0 = '0, last1 = '0;

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint unsigned half_mod(input longint unsigned x, input longint unsigned q);
        return (x * ((q + 1) / 2)) % q;
    endfunction

    task automatic send(input logic m, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        longint unsigned q, p, s, d;
        q = modulus;
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_a = a; in_b = b; in_tw = c;
        if (!m) begin
            p = (longint'(b) * c) % q;
            exp0[wr] = 32'((a + p) % q);
            exp1[wr] = 32'((a + q - p) % q);
        end else begin
            s = (longint'(a) + b) % q;
            d = (longint'(a) + q - b) % q;
            exp0[wr] = 32'(half_mod(s, q));
            exp1[wr] = 32'(half_mod((d * c) % q, q));
        end
        expm[wr]  = m;
        issue[wr] = cyc;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (rd >= wr) begin
                    check("R6 unexpected result", 1, 0);
                end else begin
                    check(expm[rd] ? "R3 inverse y0" : "R1 forward y0", out_y0, exp0[rd]);
                    check(expm[rd] ? "R4 inverse y1" : "R2 forward y1", out_y1, exp1[rd]);
                    check("R5 latency", cyc - issue[rd], LAT);
                    last0 = exp0[rd]; last1 = exp1[rd];
                    have_last = 1'b1;
                    rd++;
                end
            end else if (have_last) begin
                check("R9 hold y0", out_y0, last0);
                check("R9 hold y1", out_y1, last1);
            end
        end
    end

    initial begin
        #(4 * 20000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 valid in reset", out_valid, 0);
        check("R7 y0 in reset", out_y0, 0);
        @(negedge clk); rst = 1'b0;
        check("R7 valid after reset", out_valid, 0);
        check("R7 y1 after reset", out_y1, 0);
        mon_en = 1'b1;

        // R6: table walk, back to back, modes mixed each cycle, q near 2^32
        for (int k = 0; k < 12; k++) send(TBL[k].m, TBL[k].a, TBL[k].b, TBL[k].c);
        idle(LAT + 4);

        // small modulus with bubbles between jobs
        modulus = 32'd17;
        idle(2);
        send(1'b0, 32'd16, 32'd16, 32'd16); idle(1);
        send(1'b1, 32'd16, 32'd16, 32'd16); idle(2);
        send(1'b1, 32'd0,  32'd1,  32'd1);  idle(1);
        send(1'b0, 32'd1,  32'd16, 32'd1);
        send(1'b1, 32'd15, 32'd0,  32'd3);
        send(1'b0, 32'd9,  32'd0,  32'd4);
        idle(LAT + 4);

        check("R6 all results seen", rd, wr);
        check("R9 hold after drain y0", out_y0, last0);

        // R7: a job in flight when reset arrives is dropped
        mon_en = 1'b0;
        send(1'b0, 32'd3, 32'd4, 32'd5);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            check("R7 no result after reset", out_valid, 0);
            @(negedge clk);
        end
        check("R7 y0 cleared", out_y0, 0);
        check("R7 y1 cleared", out_y1, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule